// File: doc/BRIEF.md
# Speculative Store Buffer

This block holds stores between two load/store pipelines and the data cache until the reorder buffer confirms that each store has retired. Either pipeline can deposit a store in a clock. A store carries its reorder-buffer tag, its word address, four data bytes, byte enables and a write-through flag. Each held entry is in one of two states: speculative, or committed once its tag is reported as retired. Only committed entries leave the buffer. They leave oldest first. An ordinary store goes to the data-cache write port. A write-through store goes straight onto the external bus with no further staging.

On a misprediction, a flush drops every entry that is still speculative. Entries that have already retired are kept, and they drain as normal. If both pipelines present a store in the same clock, the lower-numbered pipeline is taken as the older store and is placed first. When space runs short, the request that cannot be placed is held off with a stall. Queue order is program order.

Top module: `spec_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `cache_req`, `bus_req` and both `wr_stall` bits are 0.
- R2: A store presented on a unit whose request is not stalled is captured at that clock edge. Stores captured in one edge are ordered with unit 0 before unit 1. Stores captured in different edges are ordered by capture time.
- R3: The free space is the depth (4) minus the occupancy registered before the edge. Requests are granted in unit order while free space remains. A request that gets no space sees its `wr_stall` bit high in the same cycle and is not stored. Space freed by a drain in a cycle becomes usable only from the next cycle.
- R4: A speculative entry at the head of the queue raises neither `cache_req` nor `bus_req`, whatever the grant inputs do.
- R5: When `ret_valid` is high, the valid speculative entry whose tag equals `ret_tag` becomes committed at that edge. A tag that matches no entry changes nothing.
- R6: When the oldest entry is committed, `out_addr`, `out_data` and `out_be` show its fields. `cache_req` is raised when its write-through flag is 0 and `bus_req` when it is 1. These outputs hold steady until the matching grant, and each grant removes exactly one entry.
- R7: A flush removes every speculative entry at that edge and keeps the committed ones, which drain afterwards in their original order. Stores presented during a flush are discarded without a stall. A retire in the flush cycle takes effect before the flush, so that entry survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 2 | Store request, one bit per load/store unit |
| wr_tag | input | 2x4 | Reorder-buffer tag per unit |
| wr_addr | input | 2x32 | Store address per unit |
| wr_data | input | 2x32 | Store data per unit |
| wr_be | input | 2x4 | Byte enables per unit |
| wr_wt | input | 2 | Write-through flag per unit |
| wr_stall | output | 2 | Request not accepted this cycle, per unit |
| ret_valid | input | 1 | Retire notification valid |
| ret_tag | input | 4 | Tag of the retiring store |
| flush | input | 1 | Misprediction flush |
| cache_req | output | 1 | Committed head entry ready for the data cache |
| cache_gnt | input | 1 | Data cache accepts the head entry |
| bus_req | output | 1 | Committed write-through head entry ready for the bus |
| bus_gnt | input | 1 | Bus accepts the head entry |
| out_addr | output | 32 | Address of the head entry |
| out_data | output | 32 | Data of the head entry |
| out_be | output | 4 | Byte enables of the head entry |

## Verification
The checks assume that live entries never share a reorder-buffer tag. They also assume that retire notifications arrive in program order, so committed entries always form a prefix of the queue. The directed tests use distinct tags for every store that is live at one time. They retire stores oldest first, except for probes whose tag is absent from the buffer. Grants are raised only while observing the request, or while no committed entry exists, so a grant never meets an unrelated head.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

    parameter int TAG_W  = 4;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic              valid;
        logic              committed;
        logic              wt;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } entry_t;

endpackage

// File: rtl/ssb_alloc.sv
module ssb_alloc #(
    parameter int DEPTH     = 4,
    parameter int NUM_UNITS = 2,
    parameter int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [CNT_W-1:0]                    count,
    input  logic [NUM_UNITS-1:0]                req,
    input  logic                                flush,
    output logic [NUM_UNITS-1:0]                grant,
    output logic [NUM_UNITS-1:0]                stall,
    output logic [NUM_UNITS-1:0][CNT_W-1:0]     offs,
    output logic [CNT_W-1:0]                    ngrant
);

    logic [CNT_W-1:0] free_c;
    logic [CNT_W-1:0] used_c;

    // Units are served in index order; a lower index is the older store.
    always_comb begin
        free_c = CNT_W'(DEPTH) - count;
        used_c = '0;
        grant  = '0;
        stall  = '0;
        offs   = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            offs[u] = used_c;
            if (req[u] && !flush) begin
                if (used_c < free_c) begin
                    grant[u] = 1'b1;
                    used_c   = used_c + CNT_W'(1);
                end else begin
                    stall[u] = 1'b1;
                end
            end
        end
        ngrant = used_c;
    end

    generate
        for (genvar g = 1; g < NUM_UNITS; g++) begin : g_order
            assert_stall_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (stall[g-1] && req[g]) |-> stall[g]);
        end
    endgenerate

endmodule

// File: rtl/ssb_retire_match.sv
module ssb_retire_match #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0]            valid_vec,
    input  logic [DEPTH-1:0]            commit_vec,
    input  logic [DEPTH-1:0][TAG_W-1:0] tags,
    input  logic                        ret_valid,
    input  logic [TAG_W-1:0]            ret_tag,
    output logic [DEPTH-1:0]            hit
);

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
            assign hit[i] = ret_valid && valid_vec[i] && !commit_vec[i] && (tags[i] == ret_tag);
        end
    endgenerate

    // Live tags are unique, so at most one entry answers a retire.
    assert_unique_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/ssb_drain.sv
module ssb_drain
    import ssb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  entry_t            head_ent,
    input  logic              cache_gnt,
    input  logic              bus_gnt,
    output logic              cache_req,
    output logic              bus_req,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [BE_W-1:0]   out_be,
    output logic              pop
);

    logic ready;

    always_comb begin
        ready     = head_ent.valid && head_ent.committed;
        cache_req = ready && !head_ent.wt;
        bus_req   = ready && head_ent.wt;
        out_addr  = head_ent.addr;
        out_data  = head_ent.data;
        out_be    = head_ent.be;
        pop       = (cache_req && cache_gnt) || (bus_req && bus_gnt);
    end

    assert_one_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cache_req, bus_req}));

    assert_cache_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_req && !cache_gnt) |=> (cache_req && $stable(out_addr) && $stable(out_data)));

    assert_bus_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(out_addr) && $stable(out_be)));

endmodule

// File: rtl/spec_store_buffer.sv
module spec_store_buffer
    import ssb_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int NUM_UNITS = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_UNITS-1:0]              wr_valid,
    input  logic [NUM_UNITS-1:0][TAG_W-1:0]   wr_tag,
    input  logic [NUM_UNITS-1:0][ADDR_W-1:0]  wr_addr,
    input  logic [NUM_UNITS-1:0][DATA_W-1:0]  wr_data,
    input  logic [NUM_UNITS-1:0][BE_W-1:0]    wr_be,
    input  logic [NUM_UNITS-1:0]              wr_wt,
    output logic [NUM_UNITS-1:0]              wr_stall,
    input  logic                              ret_valid,
    input  logic [TAG_W-1:0]                  ret_tag,
    input  logic                              flush,
    output logic                              cache_req,
    input  logic                              cache_gnt,
    output logic                              bus_req,
    input  logic                              bus_gnt,
    output logic [ADDR_W-1:0]                 out_addr,
    output logic [DATA_W-1:0]                 out_data,
    output logic [BE_W-1:0]                   out_be
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic [PTR_W-1:0]   head;
        logic [PTR_W-1:0]   tail;
        logic [CNT_W-1:0]   count;
    } state_t;

    state_t st_q, st_d;

    logic [DEPTH-1:0]                  valid_vec, commit_vec, hit;
    logic [DEPTH-1:0][TAG_W-1:0]       tag_vec;
    logic [NUM_UNITS-1:0]              grant;
    logic [NUM_UNITS-1:0][CNT_W-1:0]   offs;
    logic [CNT_W-1:0]                  ngrant;
    logic                              pop;
    logic [CNT_W-1:0]                  keep_c;

    function automatic logic [PTR_W-1:0] ptr_add(input logic [PTR_W-1:0] p, input int n);
        return PTR_W'((int'(p) + n) % DEPTH);
    endfunction

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_vec
            assign valid_vec[i]  = st_q.ent[i].valid;
            assign commit_vec[i] = st_q.ent[i].committed;
            assign tag_vec[i]    = st_q.ent[i].tag;
        end
    endgenerate

    ssb_alloc #(.DEPTH(DEPTH), .NUM_UNITS(NUM_UNITS), .CNT_W(CNT_W)) alloc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .count  (st_q.count),
        .req    (wr_valid),
        .flush  (flush),
        .grant  (grant),
        .stall  (wr_stall),
        .offs   (offs),
        .ngrant (ngrant)
    );

    ssb_retire_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) match_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (valid_vec),
        .commit_vec (commit_vec),
        .tags       (tag_vec),
        .ret_valid  (ret_valid),
        .ret_tag    (ret_tag),
        .hit        (hit)
    );

    ssb_drain drain_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_ent  (st_q.ent[st_q.head]),
        .cache_gnt (cache_gnt),
        .bus_gnt   (bus_gnt),
        .cache_req (cache_req),
        .bus_req   (bus_req),
        .out_addr  (out_addr),
        .out_data  (out_data),
        .out_be    (out_be),
        .pop       (pop)
    );

    always_comb begin
        st_d   = st_q;
        keep_c = '0;

        // Retire marking comes first so a same-cycle flush keeps the entry.
        for (int i = 0; i < DEPTH; i++) begin
            if (hit[i]) st_d.ent[i].committed = 1'b1;
        end

        if (pop) begin
            st_d.ent[st_q.head].valid     = 1'b0;
            st_d.ent[st_q.head].committed = 1'b0;
            st_d.head = ptr_add(st_q.head, 1);
        end

        if (flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (st_d.ent[i].valid && !st_d.ent[i].committed) begin
                    st_d.ent[i].valid = 1'b0;
                end
                if (st_d.ent[i].valid) keep_c = keep_c + CNT_W'(1);
            end
            st_d.count = keep_c;
            st_d.tail  = ptr_add(st_d.head, int'(keep_c));
        end else begin
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (grant[u]) begin
                    st_d.ent[ptr_add(st_q.tail, int'(offs[u]))] = '{
                        valid:     1'b1,
                        committed: 1'b0,
                        wt:        wr_wt[u],
                        tag:       wr_tag[u],
                        addr:      wr_addr[u],
                        data:      wr_data[u],
                        be:        wr_be[u]
                    };
                end
            end
            st_d.tail  = ptr_add(st_q.tail, int'(ngrant));
            st_d.count = st_q.count + ngrant - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));

    assert_count_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(valid_vec) == int'(st_q.count));

    assert_flush_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((valid_vec & ~commit_vec) == '0));

    assert_spec_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_vec[st_q.head] && !commit_vec[st_q.head]) |-> !(cache_req || bus_req));

endmodule

// File: tb/spec_store_buffer_tb_top.sv
module spec_store_buffer_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        wr_valid = '0;
    logic [1:0][3:0]   wr_tag = '0;
    logic [1:0][31:0]  wr_addr = '0;
    logic [1:0][31:0]  wr_data = '0;
    logic [1:0][3:0]   wr_be = '0;
    logic [1:0]        wr_wt = '0;
    logic [1:0]        wr_stall;
    logic              ret_valid = 1'b0;
    logic [3:0]        ret_tag = '0;
    logic              flush = 1'b0;
    logic              cache_req, bus_req;
    logic              cache_gnt = 1'b0;
    logic              bus_gnt = 1'b0;
    logic [31:0]       out_addr, out_data;
    logic [3:0]        out_be;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    spec_store_buffer dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_tag(wr_tag), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_be(wr_be), .wr_wt(wr_wt), .wr_stall(wr_stall),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .flush(flush),
        .cache_req(cache_req), .cache_gnt(cache_gnt),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .out_addr(out_addr), .out_data(out_data), .out_be(out_be)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_wr(input int u, input logic [3:0] tag, input logic [31:0] a,
                          input logic [31:0] d, input logic [3:0] be, input logic wt);
        wr_valid[u] = 1'b1; wr_tag[u] = tag; wr_addr[u] = a;
        wr_data[u] = d; wr_be[u] = be; wr_wt[u] = wt;
    endtask

    task automatic retire(input logic [3:0] tag);
        ret_valid = 1'b1; ret_tag = tag;
        tick();
        ret_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cache_req", {31'd0, cache_req}, 32'd0);
        chk("R1 bus_req",   {31'd0, bus_req},   32'd0);
        chk("R1 stall",     {30'd0, wr_stall},  32'd0);
    endtask

    task automatic t_spec_retire();
        set_wr(0, 4'd3, 32'h1000_0010, 32'hCAFE_0001, 4'hF, 1'b0);
        tick();
        wr_valid = '0;
        cache_gnt = 1'b1; bus_gnt = 1'b1;
        for (int k = 0; k < 3; k++) begin
            chk("R4 speculative head quiet", {30'd0, cache_req, bus_req}, 32'd0);
            tick();
        end
        cache_gnt = 1'b0; bus_gnt = 1'b0;
        retire(4'd9);
        chk("R5 unmatched tag no effect", {30'd0, cache_req, bus_req}, 32'd0);
        retire(4'd3);
        chk("R5 retire commits", {31'd0, cache_req}, 32'd1);
        chk("R6 head addr", out_addr, 32'h1000_0010);
        chk("R6 head data", out_data, 32'hCAFE_0001);
        chk("R6 head be", {28'd0, out_be}, 32'hF);
        tick();
        chk("R6 held without grant", {31'd0, cache_req}, 32'd1);
        chk("R6 addr stable", out_addr, 32'h1000_0010);
        cache_gnt = 1'b1;
        tick();
        cache_gnt = 1'b0;
        chk("R6 one pop per grant", {30'd0, cache_req, bus_req}, 32'd0);
    endtask

    task automatic t_order();
        set_wr(0, 4'd1, 32'h2000_0000, 32'h1111_1111, 4'hF, 1'b0);
        set_wr(1, 4'd2, 32'h2000_0004, 32'h2222_2222, 4'h3, 1'b1);
        #1 chk("R2 dual write no stall", {30'd0, wr_stall}, 32'd0);
        tick();
        wr_valid = '0;
        retire(4'd1);
        chk("R2 unit0 older", out_addr, 32'h2000_0000);
        chk("R6 cache path", {30'd0, cache_req, bus_req}, 32'd2);
        retire(4'd2);
        cache_gnt = 1'b1;
        tick();
        cache_gnt = 1'b0;
        chk("R6 wt to bus", {30'd0, cache_req, bus_req}, 32'd1);
        chk("R2 unit1 next", out_addr, 32'h2000_0004);
        chk("R6 wt be", {28'd0, out_be}, 32'h3);
        bus_gnt = 1'b1;
        tick();
        bus_gnt = 1'b0;
        chk("R6 bus drained", {30'd0, cache_req, bus_req}, 32'd0);
    endtask

    task automatic t_full();
        set_wr(0, 4'd4, 32'h3000_0000, 32'h0, 4'hF, 1'b0);
        set_wr(1, 4'd5, 32'h3000_0004, 32'h0, 4'hF, 1'b0);
        tick();
        set_wr(0, 4'd6, 32'h3000_0008, 32'h0, 4'hF, 1'b0);
        set_wr(1, 4'd7, 32'h3000_000C, 32'h0, 4'hF, 1'b0);
        tick();
        wr_valid = '0;
        set_wr(0, 4'd8, 32'h3000_0010, 32'h0, 4'hF, 1'b0);
        #1 chk("R3 stall when full", {30'd0, wr_stall}, 32'd1);
        tick();
        wr_valid = '0;
        flush = 1'b1;
        tick();
        flush = 1'b0;
        for (int k = 0; k < 3; k++) begin
            set_wr(0, 4'(8 + k), 32'h4000_0000 + 32'(4 * k), 32'h0, 4'hF, 1'b0);
            #1 chk("R7 flush emptied", {30'd0, wr_stall}, 32'd0);
            tick();
        end
        set_wr(0, 4'd11, 32'h4000_000C, 32'h0, 4'hF, 1'b0);
        set_wr(1, 4'd12, 32'h4000_0010, 32'h0, 4'hF, 1'b0);
        #1 chk("R3 unit1 stalled with one slot", {30'd0, wr_stall}, 32'd2);
        tick();
        wr_valid = '0;
        for (int k = 8; k < 12; k++) retire(4'(k));
        cache_gnt = 1'b1;
        for (int k = 0; k < 4; k++) begin
            chk("R6 drain in order", out_addr, 32'h4000_0000 + 32'(4 * k));
            chk("R6 drain req", {31'd0, cache_req}, 32'd1);
            tick();
        end
        cache_gnt = 1'b0;
        chk("R3 stalled store not stored", {30'd0, cache_req, bus_req}, 32'd0);
    endtask

    task automatic t_flush_mixed();
        for (int k = 0; k < 3; k++) begin
            set_wr(0, 4'(4 + k), 32'h5000_0000 + 32'(4 * k), 32'h0, 4'hF, 1'(k == 1));
            tick();
        end
        wr_valid = '0;
        retire(4'd4);
        flush = 1'b1; ret_valid = 1'b1; ret_tag = 4'd5;
        set_wr(0, 4'd7, 32'h5000_0040, 32'h0, 4'hF, 1'b0);
        #1 chk("R7 flush write not stalled", {30'd0, wr_stall}, 32'd0);
        tick();
        flush = 1'b0; ret_valid = 1'b0; wr_valid = '0;
        chk("R7 committed kept", out_addr, 32'h5000_0000);
        chk("R7 committed drains", {30'd0, cache_req, bus_req}, 32'd2);
        cache_gnt = 1'b1;
        tick();
        cache_gnt = 1'b0;
        chk("R7 same-cycle retire survives", out_addr, 32'h5000_0004);
        chk("R7 survivor wt path", {30'd0, cache_req, bus_req}, 32'd1);
        bus_gnt = 1'b1;
        tick();
        bus_gnt = 1'b0;
        chk("R7 speculative dropped", {30'd0, cache_req, bus_req}, 32'd0);
        retire(4'd6);
        retire(4'd7);
        chk("R7 dropped entries stay gone", {30'd0, cache_req, bus_req}, 32'd0);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_spec_retire();
        t_order();
        t_full();
        t_flush_mixed();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule